// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block is a register-mapped sequencer for a few power domains. Each domain holds a fixed number of gated modules. Software stages changes in control registers: a requested state for each module, plus a power-on request for the domain. It then writes a per-domain go bit. After a fixed number of clock cycles the domain takes on all of its staged values in the same cycle, and its busy bit clears.

Software polls a transition status register for the busy bits. It reads back each module's current state and whether that module's clock is running. It also reads each domain's power state.

The block drives three sets of outputs: a per-module clock enable, a per-module local reset, and a per-domain power-on signal. Actual power switches, isolation and clock gating cells sit outside the block and use these outputs.

Top module: `pmsc_top`

## Requirements
- R1: After synchronous reset, every domain is off, every module's current state is 0, all busy bits are clear, every clock enable is low and every local reset is high.
- R2: The module control register at 0xA00+4*m keeps bits [5:0] (requested state), bit 8 (local reset release, active high) and bit 31 (force), and returns them on read. All other bits read 0. The domain control register at 0x300+4*d keeps only bit 0 (power-on request).
- R3: Writing a control register changes no output and no status register until that domain's transition commits.
- R4: Writing 0x120 with bit d set starts a transition for domain d. Bit d of 0x128 reads 1 for exactly LATENCY cycles. The transition commits on the clock edge LATENCY cycles after the write edge, and then the busy bit clears.
- R5: On commit, bits [5:0] of module status (0x800+4*m) equal the requested state staged for each module of that domain. Domain status (0x200+4*d) reads 1 when the staged power request was set and 0 when it was not.
- R6: A go bit for a domain that is already busy is ignored. It neither restarts nor extends the running transition.
- R7: A module's clock enable, and bit 12 of its status, is 1 only when the module's current state is 3 (enable) and its domain is on.
- R8: A module's local reset is high when its committed bit 8 is 0, or when its current state is 0 (software reset disable) or 1 (synchronous reset).
- R9: Reads of unmapped or misaligned addresses, and of the write-only command register, return 0. Writes to status registers have no effect.
- R10: A transition on one domain leaves the state and outputs of every other domain's modules unchanged.
- R11: LATENCY lies between 1 and 65534 cycles, so every transition ends well within a 65535-poll software limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe; data appears on rdata after the next edge |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| mod_clk_en | output | NUM_DOM*MODS_PER_DOM | Per-module clock enable |
| mod_lrst | output | NUM_DOM*MODS_PER_DOM | Per-module local reset, active high |
| dom_pwr_on | output | NUM_DOM | Per-domain power-on |

## Verification
A busy counter that loads or counts wrongly shows up as a change in dom_pwr_on or mod_clk_en one or more cycles away from the expected edge. A busy counter that restarts when it should not has the same effect. The bench times these output edges to the exact cycle. A wrongly captured requested state or reset bit appears at the clock-enable and local-reset pins in the cycle of the commit. It also appears in the next status read. A decode slip that aliases a register shows up on the first readback of a neighbouring register, because the bench reads every mapped register after each random transition.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;

    // Register offsets (software decodes these)
    localparam logic [11:0] OFF_XCMD     = 12'h120;
    localparam logic [11:0] OFF_XSTAT    = 12'h128;
    localparam logic [11:0] OFF_DOM_STAT = 12'h200;
    localparam logic [11:0] OFF_DOM_CTRL = 12'h300;
    localparam logic [11:0] OFF_MOD_STAT = 12'h800;
    localparam logic [11:0] OFF_MOD_CTRL = 12'hA00;

    typedef logic [5:0] mstate_t;

    localparam mstate_t ST_SWRST_DIS = 6'd0;
    localparam mstate_t ST_SYNC_RST  = 6'd1;
    localparam mstate_t ST_DISABLE   = 6'd2;
    localparam mstate_t ST_ENABLE    = 6'd3;

    typedef struct packed {
        logic    force_bit;
        logic    lrst_n;
        mstate_t req;
    } mod_ctrl_t;

    localparam mod_ctrl_t MOD_CTRL_RST = '{force_bit: 1'b0, lrst_n: 1'b1, req: ST_SWRST_DIS};

    function automatic logic [11:0] reg_addr(logic [11:0] base, int idx);
        return base + 12'(idx * 4);
    endfunction

    function automatic logic [31:0] pack_ctrl(mod_ctrl_t c);
        return {c.force_bit, 22'b0, c.lrst_n, 2'b0, c.req};
    endfunction

    function automatic mod_ctrl_t unpack_ctrl(logic [31:0] w);
        mod_ctrl_t c;
        c.force_bit = w[31];
        c.lrst_n    = w[8];
        c.req       = w[5:0];
        return c;
    endfunction

    function automatic logic [31:0] pack_mstat(mstate_t s, logic run);
        return {19'b0, run, 6'b0, s};
    endfunction

    function automatic logic [31:0] pack_dstat(logic on);
        return {27'b0, 4'b0, on};
    endfunction

endpackage

// File: rtl/pmsc_regs.sv
module pmsc_regs
    import pmsc_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int NUM_MOD = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [11:0]                addr,
    input  logic [31:0]                wdata,
    input  logic [NUM_DOM-1:0]         busy,
    input  logic [NUM_DOM-1:0]         dom_on,
    input  mstate_t [NUM_MOD-1:0]      mod_state,
    input  logic [NUM_MOD-1:0]         mod_run,
    output logic [NUM_DOM-1:0]         go,
    output mod_ctrl_t [NUM_MOD-1:0]    mod_ctrl,
    output logic [NUM_DOM-1:0]         dom_req_on,
    output logic [31:0]                rdata
);

    mod_ctrl_t [NUM_MOD-1:0] ctrl_q;
    logic [NUM_DOM-1:0]      dreq_q;
    logic [31:0]             rd_val;
    logic                    rd_hit;
    logic [31:0]             rdata_q;

    // Staged control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < NUM_MOD; m++) ctrl_q[m] <= MOD_CTRL_RST;
            dreq_q <= '0;
        end else if (wr_en) begin
            for (int m = 0; m < NUM_MOD; m++)
                if (addr == reg_addr(OFF_MOD_CTRL, m)) ctrl_q[m] <= unpack_ctrl(wdata);
            for (int d = 0; d < NUM_DOM; d++)
                if (addr == reg_addr(OFF_DOM_CTRL, d)) dreq_q[d] <= wdata[0];
        end
    end

    assign go         = (wr_en && addr == OFF_XCMD) ? wdata[NUM_DOM-1:0] : '0;
    assign mod_ctrl   = ctrl_q;
    assign dom_req_on = dreq_q;

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        if (addr == OFF_XSTAT) begin
            rd_val[NUM_DOM-1:0] = busy;
            rd_hit = 1'b1;
        end
        for (int d = 0; d < NUM_DOM; d++) begin
            if (addr == reg_addr(OFF_DOM_STAT, d)) begin
                rd_val = pack_dstat(dom_on[d]);
                rd_hit = 1'b1;
            end
            if (addr == reg_addr(OFF_DOM_CTRL, d)) begin
                rd_val = {31'b0, dreq_q[d]};
                rd_hit = 1'b1;
            end
        end
        for (int m = 0; m < NUM_MOD; m++) begin
            if (addr == reg_addr(OFF_MOD_STAT, m)) begin
                rd_val = pack_mstat(mod_state[m], mod_run[m]);
                rd_hit = 1'b1;
            end
            if (addr == reg_addr(OFF_MOD_CTRL, m)) begin
                rd_val = pack_ctrl(ctrl_q[m]);
                rd_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;

    // R9: a miss on the decoder yields zero data on the next cycle
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_hit) |=> (rdata == '0));

    // R2: reserved control bits never read back as set
    p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_MOD_CTRL) |=> (rdata[30:9] == '0 && rdata[7:6] == '0));

endmodule

// File: rtl/pmsc_dom_seq.sv
module pmsc_dom_seq #(
    parameter int LATENCY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic req_on,
    output logic busy,
    output logic commit,
    output logic pwr_on
);

    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LAT_LOAD = CW'(LATENCY);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          on_q;

    assign commit = busy_q && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            on_q   <= 1'b0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                cnt_q  <= LAT_LOAD;
            end
        end else if (cnt_q == ONE) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            on_q   <= req_on;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy   = busy_q;
    assign pwr_on = on_q;

    // R4: busy stays up until the count runs out
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != ONE) |=> busy_q);

    // R4: the commit cycle is followed by idle
    p_busy_clear_r4: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy_q);

    // R4: a go on an idle domain raises busy with a full count
    p_go_start_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && go) |=> (busy_q && cnt_q == LAT_LOAD));

    // R6: a go while busy does not reload the counter
    p_go_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && go && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R3: domain power only moves on commit
    p_power_staged_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(on_q));

endmodule

// File: rtl/pmsc_mod_unit.sv
module pmsc_mod_unit
    import pmsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  logic    dom_on,
    input  mstate_t req,
    input  logic    req_lrst_n,
    output mstate_t state,
    output logic    clk_en,
    output logic    lrst
);

    mstate_t state_q;
    logic    lrn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SWRST_DIS;
            lrn_q   <= 1'b1;
        end else if (commit) begin
            state_q <= req;
            lrn_q   <= req_lrst_n;
        end
    end

    assign state  = state_q;
    assign clk_en = dom_on && (state_q == ST_ENABLE);
    assign lrst   = !lrn_q || (state_q == ST_SWRST_DIS) || (state_q == ST_SYNC_RST);

    // R3: committed values hold between commits
    p_state_staged_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(state_q) && $stable(lrn_q)));

    // R5: commit takes the staged request
    p_commit_take_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (state_q == $past(req)));

    // R7: a running clock needs a powered domain
    p_clk_needs_power_r7: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> dom_on);

    // R8: both reset states hold the module in local reset
    p_reset_states_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWRST_DIS || state_q == ST_SYNC_RST) |-> lrst);

endmodule

// File: rtl/pmsc_top.sv
module pmsc_top
    import pmsc_pkg::*;
#(
    parameter int NUM_DOM      = 2,
    parameter int MODS_PER_DOM = 2,
    parameter int LATENCY      = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [11:0]                         addr,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         rdata,
    output logic [NUM_DOM*MODS_PER_DOM-1:0]     mod_clk_en,
    output logic [NUM_DOM*MODS_PER_DOM-1:0]     mod_lrst,
    output logic [NUM_DOM-1:0]                  dom_pwr_on
);

    localparam int NUM_MOD = NUM_DOM * MODS_PER_DOM;

    logic [NUM_DOM-1:0]      go;
    logic [NUM_DOM-1:0]      busy;
    logic [NUM_DOM-1:0]      commit;
    logic [NUM_DOM-1:0]      dom_req_on;
    mod_ctrl_t [NUM_MOD-1:0] mod_ctrl;
    mstate_t [NUM_MOD-1:0]   mod_state;

    // R11: latency must fit the software poll bound
    initial begin
        p_latency_bound_r11: assert (LATENCY >= 1 && LATENCY <= 65534)
            else $error("LATENCY out of range");
    end

    pmsc_regs #(
        .NUM_DOM (NUM_DOM),
        .NUM_MOD (NUM_MOD)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .busy       (busy),
        .dom_on     (dom_pwr_on),
        .mod_state  (mod_state),
        .mod_run    (mod_clk_en),
        .go         (go),
        .mod_ctrl   (mod_ctrl),
        .dom_req_on (dom_req_on),
        .rdata      (rdata)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pmsc_dom_seq #(
            .LATENCY (LATENCY)
        ) seq_i (
            .clk    (clk),
            .rst    (rst),
            .go     (go[d]),
            .req_on (dom_req_on[d]),
            .busy   (busy[d]),
            .commit (commit[d]),
            .pwr_on (dom_pwr_on[d])
        );
    end

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        pmsc_mod_unit unit_i (
            .clk        (clk),
            .rst        (rst),
            .commit     (commit[m / MODS_PER_DOM]),
            .dom_on     (dom_pwr_on[m / MODS_PER_DOM]),
            .req        (mod_ctrl[m].req),
            .req_lrst_n (mod_ctrl[m].lrst_n),
            .state      (mod_state[m]),
            .clk_en     (mod_clk_en[m]),
            .lrst       (mod_lrst[m])
        );
    end

    // R1: first cycle out of reset is fully quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dom_pwr_on == '0 && mod_clk_en == '0 && (&mod_lrst) && busy == '0));

    // R10: a domain that does not commit keeps its modules' clocks
    p_domain_isolated_r10: assert property (@(posedge clk) disable iff (rst)
        (commit == '0) |=> $stable(mod_clk_en));

endmodule

// File: tb/pmsc_top_tb_top.sv
`timescale 1ns/1ps
module pmsc_top_tb_top;

    localparam int ND  = 2;
    localparam int MPD = 2;
    localparam int NM  = ND * MPD;
    localparam int LAT = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NM-1:0] mod_clk_en;
    logic [NM-1:0] mod_lrst;
    logic [ND-1:0] dom_pwr_on;

    int n_checks = 0;
    int n_err    = 0;

    // Bench model
    logic [5:0] m_req   [NM];
    logic       m_lrn   [NM];
    logic       m_force [NM];
    logic       d_req   [ND];
    logic [5:0] c_state [NM];
    logic       c_lrn   [NM];
    logic       c_on    [ND];

    always #4 clk = ~clk;

    pmsc_top #(
        .NUM_DOM      (ND),
        .MODS_PER_DOM (MPD),
        .LATENCY      (LAT)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .mod_clk_en (mod_clk_en),
        .mod_lrst   (mod_lrst),
        .dom_pwr_on (dom_pwr_on)
    );

    function automatic logic e_clk(int m);
        return (c_state[m] == 6'd3) && c_on[m / MPD];
    endfunction

    function automatic logic e_lrst(int m);
        return !c_lrn[m] || (c_state[m] == 6'd0) || (c_state[m] == 6'd1);
    endfunction

    function automatic logic [31:0] e_mstat(int m);
        return {19'b0, e_clk(m), 6'b0, c_state[m]};
    endfunction

    function automatic logic [31:0] e_mctrl(int m);
        return {m_force[m], 22'b0, m_lrn[m], 2'b0, m_req[m]};
    endfunction

    function automatic logic [NM-1:0] e_clk_vec();
        logic [NM-1:0] v;
        for (int m = 0; m < NM; m++) v[m] = e_clk(m);
        return v;
    endfunction

    function automatic logic [NM-1:0] e_lrst_vec();
        logic [NM-1:0] v;
        for (int m = 0; m < NM; m++) v[m] = e_lrst(m);
        return v;
    endfunction

    function automatic logic [ND-1:0] e_on_vec();
        logic [ND-1:0] v;
        for (int d = 0; d < ND; d++) v[d] = c_on[d];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_mod(input int m, input logic [5:0] st, input logic lrn, input logic frc);
        m_req[m] = st; m_lrn[m] = lrn; m_force[m] = frc;
        bus_wr(12'hA00 + 12'(4 * m), {frc, 22'h3FFFFF, lrn, 2'b11, st});
    endtask

    task automatic set_dom(input int d, input logic on);
        d_req[d] = on;
        bus_wr(12'h300 + 12'(4 * d), {31'h7FFF_FFFF, on});
    endtask

    task automatic model_commit(input int d);
        for (int m = d * MPD; m < (d + 1) * MPD; m++) begin
            c_state[m] = m_req[m];
            c_lrn[m]   = m_lrn[m];
        end
        c_on[d] = d_req[d];
    endtask

    task automatic chk_pins(input string req);
        chk({req, " clk_en"}, 32'(mod_clk_en), 32'(e_clk_vec()));
        chk({req, " lrst"},   32'(mod_lrst),   32'(e_lrst_vec()));
        chk({req, " pwr_on"}, 32'(dom_pwr_on), 32'(e_on_vec()));
    endtask

    task automatic chk_regs(input string req);
        logic [31:0] v;
        for (int m = 0; m < NM; m++) begin
            bus_rd(12'h800 + 12'(4 * m), v);
            chk({req, " mod status"}, v, e_mstat(m));
        end
        for (int d = 0; d < ND; d++) begin
            bus_rd(12'h200 + 12'(4 * d), v);
            chk({req, " dom status"}, v, {31'b0, c_on[d]});
        end
    endtask

    // Go, check busy during the window, then wait until after commit
    task automatic do_go(input int d);
        logic [31:0] v;
        bus_wr(12'h120, 32'(1) << d);
        bus_rd(12'h128, v);
        chk("R4 busy set", v, 32'(1) << d);
        repeat (LAT - 1) @(negedge clk);
        model_commit(d);
        bus_rd(12'h128, v);
        chk("R4 busy clear", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int m = 0; m < NM; m++) begin
            m_req[m] = 6'd0; m_lrn[m] = 1'b1; m_force[m] = 1'b0;
            c_state[m] = 6'd0; c_lrn[m] = 1'b1;
        end
        for (int d = 0; d < ND; d++) begin
            d_req[d] = 1'b0; c_on[d] = 1'b0;
        end

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_pins("R1");
        chk_regs("R1");
        bus_rd(12'h128, v);
        chk("R1 busy", v, 32'h0);

        // R2 readback with reserved bits set
        set_mod(0, 6'h3F, 1'b1, 1'b1);
        bus_rd(12'hA00, v);
        chk("R2 mod ctrl", v, 32'h8000_013F);
        set_dom(0, 1'b1);
        bus_rd(12'h300, v);
        chk("R2 dom ctrl", v, 32'h1);

        // R3 staged only
        set_mod(0, 6'd3, 1'b1, 1'b0);
        set_mod(1, 6'd2, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk_pins("R3");
        chk_regs("R3");

        // R4/R5/R7 exact commit edge from the pins
        bus_wr(12'h120, 32'h1);
        for (int i = 1; i <= LAT + 1; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < LAT) chk("R4 no early commit", 32'(dom_pwr_on), 32'h0);
            if (i == LAT) begin
                model_commit(0);
                chk("R4 commit edge", 32'(dom_pwr_on), 32'h1);
                chk_pins("R7");
            end
        end
        chk_regs("R5");

        // R6 second go during busy is ignored
        set_mod(1, 6'd3, 1'b1, 1'b0);
        bus_wr(12'h120, 32'h1);
        for (int i = 1; i <= LAT + 1; i++) begin
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            if (i < LAT) chk("R6 mod1 clk held", 32'(mod_clk_en[1]), 32'h0);
            if (i == LAT) begin
                model_commit(0);
                chk("R6 commit not restarted", 32'(mod_clk_en[1]), 32'h1);
            end
            if (i == 3) begin
                wr_en = 1'b1; addr = 12'h120; wdata = 32'h1;
            end
        end
        chk_pins("R6");

        // R8 local reset from bit 8 with state enable
        set_mod(0, 6'd3, 1'b0, 1'b0);
        do_go(0);
        chk("R8 lrst bit8", 32'(mod_lrst[0]), 32'h1);
        chk_pins("R8");
        set_mod(0, 6'd1, 1'b1, 1'b0);
        do_go(0);
        chk("R8 sync reset state", 32'(mod_lrst[0]), 32'h1);

        // R10 domain 1 transition, domain 0 staged but untouched
        set_mod(1, 6'd0, 1'b1, 1'b0);
        set_mod(2, 6'd3, 1'b1, 1'b0);
        set_dom(1, 1'b1);
        do_go(1);
        chk("R10 dom0 mod1 clock", 32'(mod_clk_en[1]), 32'h1);
        chk_pins("R10");
        chk_regs("R10");

        // R7 domain off gates an enabled module
        set_dom(1, 1'b0);
        do_go(1);
        chk("R7 power off gates clock", 32'(mod_clk_en[2]), 32'h0);
        bus_rd(12'h808, v);
        chk("R7 status run bit", v, 32'h3);

        // R9 unmapped reads and read-only writes
        bus_rd(12'h004, v);  chk("R9 unmapped 004", v, 32'h0);
        bus_rd(12'h120, v);  chk("R9 cmd reads zero", v, 32'h0);
        bus_rd(12'h208, v);  chk("R9 dom beyond count", v, 32'h0);
        bus_rd(12'h802, v);  chk("R9 misaligned", v, 32'h0);
        bus_rd(12'hA10, v);  chk("R9 ctrl beyond count", v, 32'h0);
        bus_wr(12'h800, 32'hFFFF_FFFF);
        bus_wr(12'h200, 32'hFFFF_FFFF);
        bus_wr(12'h128, 32'hFFFF_FFFF);
        chk_regs("R9 ro write");
        chk_pins("R9 ro write");

        // Random transitions
        for (int it = 0; it < 40; it++) begin
            int d;
            d = int'($urandom % ND);
            for (int m = d * MPD; m < (d + 1) * MPD; m++) begin
                logic [5:0] st;
                st = (it % 5 == 0) ? 6'($urandom % 64) : 6'($urandom % 4);
                set_mod(m, st, 1'($urandom % 2), 1'($urandom % 2));
            end
            set_dom(d, 1'($urandom % 2));
            do_go(d);
            chk_pins("R5 random");
            chk_regs("R5 random");
            for (int m = 0; m < NM; m++) begin
                bus_rd(12'hA00 + 12'(4 * m), v);
                chk("R2 random ctrl", v, e_mctrl(m));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule